// File: doc/BRIEF.md
# Single-Cycle Load/Store/ALU Processor Core

This block is a 32-bit processor core that retires one instruction per clock cycle. It holds its own program counter and a 32-entry general register file. It fetches from an external instruction memory through a combinational read port and reaches an external data memory through an address, write-data, write-enable and read-data port. The core executes eight instructions: word load, word store, four register-register operations (add, subtract, bitwise and, bitwise or), signed set-on-less-than, and branch-if-equal.

Decoding happens in two levels. A main decoder looks only at the opcode. It produces the datapath selects and a 2-bit operation class: 00 means add, 01 means subtract, 10 means the funct field decides, and 11 is unused and falls back to add. A second decoder combines that class with the funct field to produce a 3-bit ALU code: and=000, or=001, add=010, sub=110, slt=111.

Both memories are simple arrays outside the block. The data memory must return read data in the same cycle and must write on the rising edge when the write enable is high. Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], and a 16-bit immediate [15:0].

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears every register. In the first cycle after reset, imem_addr is 0.
- R2: Any instruction other than a taken branch advances the program counter by 4.
- R3: A load (opcode 100011) writes the data-memory word at rs + sign-extended immediate into register rt. The word 0x8C0B0004 loads address 4 into register 11.
- R4: A store (opcode 101011) drives dmem_addr = rs + sign-extended immediate, dmem_wdata = register rt and dmem_we = 1, and does not write a register. No other instruction raises dmem_we.
- R5: R-type (opcode 000000) writes rd with rs+rt for funct 100000, rs-rt for funct 100010, rs AND rt for funct 100100, and rs OR rt for funct 100101.
- R6: R-type with funct 101010 writes 1 into rd when rs < rt as signed 32-bit values, and writes 0 otherwise.
- R7: Branch-if-equal (opcode 000100) with equal rs and rt loads PC+4 + (sign-extended immediate << 2), including negative offsets. With unequal operands it falls through to PC+4.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any opcode other than the four above writes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Store enable, sampled at the rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr |

## Verification
The bench builds the core with the default 32-bit datapath and 32 registers. That makes the full signed range reachable, so a negative operand against a positive one separates a signed compare from an unsigned one. It also lets the all-ones immediate express a backward branch that targets itself. A 24-word program loads seeded words, runs every ALU operation into distinct registers, and tries a decoy unknown opcode and a write to register 0. It takes one branch that skips an instruction and lets another fall through, then stores every result so the bench can read it back. The bench compares the fetch address cycle by cycle against the expected path, counts store cycles, and checks each stored word against a result table.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
package sc_core_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LW    = 6'b100011;
    localparam logic [5:0] OPC_SW    = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // operation class from the main decoder
    typedef enum logic [1:0] {
        OPC_CLS_ADD   = 2'b00,
        OPC_CLS_SUB   = 2'b01,
        OPC_CLS_FUNCT = 2'b10,
        OPC_CLS_RSVD  = 2'b11
    } op_class_e;

    // ALU function code
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic      reg_we;
        logic      dst_is_rd;
        logic      src_is_imm;
        op_class_e op_class;
        logic      branch;
        logic      mem_we;
        logic      wb_from_mem;
    } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  alu_fn_e      fn,
    output logic [W-1:0] result,
    output logic         is_zero
);

    always_comb begin
        unique case (fn)
            ALU_AND: result = opnd_a & opnd_b;
            ALU_OR:  result = opnd_a | opnd_b;
            ALU_ADD: result = opnd_a + opnd_b;
            ALU_SUB: result = opnd_a - opnd_b;
            ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))};
            default: result = opnd_a + opnd_b;
        endcase
    end

    assign is_zero = (result == '0);

endmodule

// File: rtl/sc_main_dec.sv
`timescale 1ns/1ps
module sc_main_dec
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl          = '0;
        ctrl.op_class = OPC_CLS_ADD;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.op_class  = OPC_CLS_FUNCT;
            end
            OPC_LW: begin
                ctrl.reg_we      = 1'b1;
                ctrl.src_is_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_SW: begin
                ctrl.src_is_imm = 1'b1;
                ctrl.mem_we     = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.op_class = OPC_CLS_SUB;
                ctrl.branch   = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_func_dec.sv
`timescale 1ns/1ps
module sc_func_dec
    import sc_core_pkg::*;
(
    input  op_class_e  op_class,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);

    always_comb begin
        fn = ALU_ADD;
        unique case (op_class)
            OPC_CLS_SUB: fn = ALU_SUB;
            OPC_CLS_FUNCT: begin
                unique case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_ADD;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] rsel_a,
    input  logic [$clog2(NREG)-1:0] rsel_b,
    input  logic [$clog2(NREG)-1:0] wsel,
    input  logic                    wen,
    input  logic [W-1:0]            wdat,
    output logic [W-1:0]            rdat_a,
    output logic [W-1:0]            rdat_b
);

    localparam int AW = $clog2(NREG);

    // entry 0 has no storage
    logic [W-1:0] regs_d [1:NREG-1];
    logic [W-1:0] regs_q [1:NREG-1];

    always_comb begin
        for (int i = 1; i < NREG; i++) begin
            regs_d[i] = (wen && (wsel == AW'(i))) ? wdat : regs_q[i];
        end
    end

    for (genvar g = 1; g < NREG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) regs_q[g] <= '0;
            else     regs_q[g] <= regs_d[g];
        end
    end

    assign rdat_a = (rsel_a == '0) ? '0 : regs_q[rsel_a];
    assign rdat_b = (rsel_b == '0) ? '0 : regs_q[rsel_b];

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_core_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int RAW = $clog2(NREG);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    ctrl_t           ctrl;
    alu_fn_e         alu_fn;
    logic [RAW-1:0]  f_rs, f_rt, f_rd, wr_sel;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_val;
    logic [XLEN-1:0] pc_plus4, br_tgt;
    logic            alu_zero, take_br, rf_we;

    assign f_rs    = imem_rdata[25:21];
    assign f_rt    = imem_rdata[20:16];
    assign f_rd    = imem_rdata[15:11];
    assign imm_ext = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

    sc_main_dec u_main_dec (
        .opcode (imem_rdata[31:26]),
        .ctrl   (ctrl)
    );

    sc_func_dec u_func_dec (
        .op_class (ctrl.op_class),
        .funct    (imem_rdata[5:0]),
        .fn       (alu_fn)
    );

    assign rf_we  = ctrl.reg_we;
    assign wr_sel = ctrl.dst_is_rd ? f_rd : f_rt;
    assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .rsel_a (f_rs),
        .rsel_b (f_rt),
        .wsel   (wr_sel),
        .wen    (rf_we),
        .wdat   (wb_val),
        .rdat_a (rs_val),
        .rdat_b (rt_val)
    );

    assign alu_b = ctrl.src_is_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .opnd_a  (rs_val),
        .opnd_b  (alu_b),
        .fn      (alu_fn),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

    assign pc_plus4 = st_q.pc + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign take_br  = ctrl.branch & alu_zero;

    always_comb begin
        st_d    = st_q;
        st_d.pc = take_br ? br_tgt : pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign imem_addr = st_q.pc;

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk
    import sc_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [31:0]     imem_rdata,
    input logic            dmem_we,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            rf_we
);

    logic [5:0]      op;
    logic [XLEN-1:0] br_off;
    logic            op_known;

    assign op       = imem_rdata[31:26];
    assign br_off   = {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
    assign op_known = (op == OPC_RTYPE) || (op == OPC_LW) || (op == OPC_SW) || (op == OPC_BEQ);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op != OPC_BEQ) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    // R7
    br_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && rs_val == rt_val) |=> (imem_addr == $past(imem_addr) + XLEN'(4) + $past(br_off)));

    // R7
    br_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && rs_val != rt_val) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    // R4
    store_we_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_SW) |-> (dmem_we && !rf_we));

    // R4
    we_source_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (op == OPC_SW));

    // R8
    r0_read_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[25:21] == 5'd0) |-> (rs_val == '0));

    // R9
    unknown_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> (!rf_we && !dmem_we));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .rf_we      (rf_we)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

    localparam logic [5:0] T_LW  = 6'b100011;
    localparam logic [5:0] T_SW  = 6'b101011;
    localparam logic [5:0] T_BEQ = 6'b000100;
    localparam logic [5:0] T_BAD = 6'b111111;
    localparam logic [5:0] F_ADD = 6'b100000;
    localparam logic [5:0] F_SUB = 6'b100010;
    localparam logic [5:0] F_AND = 6'b100100;
    localparam logic [5:0] F_OR  = 6'b100101;
    localparam logic [5:0] F_SLT = 6'b101010;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    localparam int NPROG = 24;
    localparam logic [31:0] PROG [NPROG] = '{
        32'h8C0B0004,                  //  0 r11 = mem[4]
        enc_i(T_LW, 5'd0, 5'd12, 16'd8),   //  1 r12 = mem[8]
        enc_i(T_LW, 5'd0, 5'd13, 16'd12),  //  2 r13 = mem[12]
        enc_r(5'd11, 5'd12, 5'd1, F_ADD),  //  3
        enc_r(5'd12, 5'd11, 5'd2, F_SUB),  //  4
        enc_r(5'd13, 5'd12, 5'd3, F_AND),  //  5
        enc_r(5'd11, 5'd13, 5'd4, F_OR),   //  6
        enc_r(5'd12, 5'd11, 5'd5, F_SLT),  //  7
        enc_r(5'd11, 5'd12, 5'd6, F_SLT),  //  8
        enc_r(5'd11, 5'd11, 5'd0, F_ADD),  //  9 write to r0
        enc_i(T_BAD, 5'd0, 5'd11, 16'd20), // 10 unknown opcode
        enc_i(T_BEQ, 5'd11, 5'd12, 16'd5), // 11 not taken
        enc_i(T_BEQ, 5'd1, 5'd1, 16'd1),   // 12 taken, skips 13
        enc_r(5'd11, 5'd11, 5'd7, F_ADD),  // 13 skipped
        enc_i(T_SW, 5'd0, 5'd1, 16'd32),   // 14
        enc_i(T_SW, 5'd0, 5'd2, 16'd36),
        enc_i(T_SW, 5'd0, 5'd3, 16'd40),
        enc_i(T_SW, 5'd0, 5'd4, 16'd44),
        enc_i(T_SW, 5'd0, 5'd5, 16'd48),
        enc_i(T_SW, 5'd0, 5'd6, 16'd52),
        enc_i(T_SW, 5'd0, 5'd0, 16'd56),
        enc_i(T_SW, 5'd0, 5'd7, 16'd60),
        enc_i(T_SW, 5'd0, 5'd11, 16'd64), // 22
        enc_i(T_BEQ, 5'd0, 5'd0, 16'hFFFF) // 23 branch to itself
    };

    typedef struct packed {
        logic [4:0]  idx;
        logic [31:0] val;
        logic [3:0]  req;
    } exp_t;

    localparam int NEXP = 12;
    localparam exp_t EXP [NEXP] = '{
        '{5'd1,  32'h00000007, 4'd3},
        '{5'd3,  32'h12345678, 4'd3},
        '{5'd16, 32'h00000007, 4'd3},  // r11 kept by the unknown opcode too
        '{5'd5,  32'hC0DE0005, 4'd9},
        '{5'd8,  32'h00000002, 4'd5},
        '{5'd9,  32'hFFFFFFF4, 4'd5},
        '{5'd10, 32'h12345678, 4'd5},
        '{5'd11, 32'h1234567F, 4'd5},
        '{5'd12, 32'h00000001, 4'd6},
        '{5'd13, 32'h00000000, 4'd6},
        '{5'd14, 32'h00000000, 4'd8},
        '{5'd15, 32'h00000000, 4'd7}   // r7 skipped, still cleared by R1
    };

    function automatic string req_tag(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] dmem [32];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    assign imem_rdata = (imem_addr[31:2] < NPROG) ? PROG[imem_addr[6:2]] : 32'h0;
    assign dmem_rdata = dmem[dmem_addr[6:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) dmem[i] <= 32'hC0DE0000 | 32'(i);
            dmem[1] <= 32'h00000007;
            dmem[2] <= 32'hFFFFFFFB;
            dmem[3] <= 32'h12345678;
        end else if (dmem_we) begin
            dmem[dmem_addr[6:2]] <= dmem_wdata;
        end
    end

    sc_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pc(input int k);
        if (k <= 12) return 32'(4 * k);
        return (4 * k + 4 > 92) ? 32'd92 : 32'(4 * k + 4);
    endfunction

    initial begin
        int we_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset fetch address", imem_addr, 32'h0);
        rst = 1'b0;
        // fetch path: fall-through R2, skip and self-branch R7
        for (int k = 0; k < 35; k++) begin
            check((k == 13 || k > 22) ? "R7 branch path" : "R2 sequential path",
                  imem_addr, exp_pc(k));
            if (dmem_we) we_cnt++;
            @(negedge clk);
        end
        // R4: exactly the nine stores raise the write enable
        check("R4 store cycle count", 32'(we_cnt), 32'd9);
        for (int e = 0; e < NEXP; e++) begin
            check(req_tag(EXP[e].req), dmem[EXP[e].idx], EXP[e].val);
        end
        // R1: reset taken while parked on the self-branch
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset from running", imem_addr, 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule